// File: doc/BRIEF.md
# Console Serial Line I/O-Instruction Controller

This block sits between a 12-bit processor's I/O-instruction bus and a simple byte-wide UART front end. It decodes 12-bit I/O-instruction words and keeps the two service flags of a console serial line: one for receive and one for transmit. During an I/O cycle it drives the processor's skip, accumulator-clear and accumulator-data lines. It also issues the transmit load and a level interrupt request. The serialiser and the baud-rate source are outside the block.

An I/O-instruction word has the opcode 6 in bits 11:9, a 6-bit device code in bits 8:3 and a 3-bit function field in bits 2:0. The line answers one of two pairs of device codes. The console pair is receiver 03 and transmitter 04 (octal). The secondary pair is receiver 36 and transmitter 37. Two instructions on device 41 choose the pair at run time, and both clear the accumulator so that software can detect that the feature exists. When the break-enable input is high, a framing error on the receive line raises a control-panel request. A monitor can use this to regain control from a running program.

Top module: `console_iot_ctrl`

## Requirements
- R1: After reset the controller answers the console pair (receiver 03, transmitter 04), the receive flag is clear, the transmit flag is set, and the control-panel request is low.
- R2: A word is acted on only while `iot_valid_i` is high, bits 11:9 equal 6, and bits 8:3 match the receiver, the transmitter or the mode device 41. Any other word changes no output and no flag.
- R3: On the receiver, function bit 0 asserts `skip_o` in the same cycle when the receive flag is set.
- R4: On the receiver, function bit 1 asserts `ac_clear_o` and clears the receive flag at the clock edge that ends the cycle (6032).
- R5: On the receiver, function bit 2 asserts `ac_drive_o` and places the received byte on `ac_data_o` bits 7:0, with bits 11:8 zero. Function 4 (6034) leaves the receive flag unchanged.
- R6: Function 6 on the receiver (6036) clears the accumulator, drives the byte, and clears the receive flag.
- R7: On the transmitter, function bit 0 skips when the transmit flag is set. Function 2 (6042) clears the transmit flag and neither clears nor drives the accumulator.
- R8: On the transmitter, function bit 2 pulses `tx_load_o` with `tx_byte_o` equal to accumulator bits 7:0. Function 4 (6044) keeps the transmit flag, and function 6 (6046) clears it.
- R9: 6412 selects the console pair, and 6413 selects the secondary pair (receiver 36, transmitter 37). Both assert `ac_clear_o` during the cycle, and the new pair takes effect from the next cycle.
- R10: `irq_o` is high exactly when the receive flag or the transmit flag is set.
- R11: `panel_req_o` is high in the cycle after a cycle in which both `rx_ferr_i` and `brk_en_i` are high, and low otherwise.
- R12: `rx_ready_i` captures `rx_byte_i` and sets the receive flag, and `tx_empty_i` sets the transmit flag. A set and a clear in the same cycle leave the flag set.
- R13: `skip_o`, `ac_clear_o`, `ac_drive_o`, `ac_data_o`, `tx_load_o` and `tx_byte_o` are combinational in the I/O cycle and are all zero outside a decoded cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iot_valid_i | input | 1 | I/O-instruction cycle strobe, one clock per instruction |
| iot_word_i | input | 12 | Instruction word |
| ac_in_i | input | 12 | Accumulator value from the processor |
| skip_o | output | 1 | Skip request |
| ac_clear_o | output | 1 | Clear-accumulator request |
| ac_drive_o | output | 1 | ac_data_o is to be ORed into the accumulator |
| ac_data_o | output | 12 | Data for the accumulator |
| irq_o | output | 1 | Interrupt request |
| panel_req_o | output | 1 | Control-panel break request |
| brk_en_i | input | 1 | Routes framing errors to panel_req_o |
| rx_byte_i | input | 8 | Received character |
| rx_ready_i | input | 1 | Received character valid strobe |
| rx_ferr_i | input | 1 | Framing error strobe |
| tx_byte_o | output | 8 | Character to transmit |
| tx_load_o | output | 1 | Transmit load strobe |
| tx_empty_i | input | 1 | Transmitter has taken the previous character |

## Verification
The bench checks the pair switch at the point where it goes wrong most easily. After 6413, the old 6031 must fall silent and 6361 must skip. A design that latched the mode late, or decoded both pairs, would skip on the wrong code. The bench checks a read without clear (6034) followed by a skip, which catches a flag cleared by the wrong function bit. It also makes a clear and a new character arrive in the same cycle, where a clear-priority design would lose the character's flag. It drives non-I/O opcodes carrying matching device bits and framing errors with break disabled, and expects no output activity. A decoder that ignored the opcode, or a break path that ignored its enable, would show up there.

// File: rtl/console_iot_pkg.sv
// Package: shared widths, instruction field layout and the decoded
// command type used by the console I/O-instruction controller.
package console_iot_pkg;

    parameter int unsigned WORD_W = 12;
    parameter int unsigned DEV_W  = 6;
    parameter int unsigned FN_W   = 3;
    parameter int unsigned OPC_W  = WORD_W - DEV_W - FN_W;

    // Opcode that marks an I/O instruction
    parameter logic [OPC_W-1:0] IOT_OPCODE = 3'o6;

    // Function bit positions (behavioural: the neighbour processor relies on them)
    parameter int unsigned FN_SKIP  = 0;
    parameter int unsigned FN_CLEAR = 1;
    parameter int unsigned FN_XFER  = 2;

    // Decoded command for one cycle
    typedef struct packed {
        logic            rx_hit;     // receiver addressed
        logic            tx_hit;     // transmitter addressed
        logic            pick_cons;  // select console pair
        logic            pick_sec;   // select secondary pair
        logic [FN_W-1:0] fn;         // function field
    } iot_cmd_t;

endpackage

// File: rtl/iot_decode.sv
// Module: iot_decode
// Purpose: splits an instruction word into opcode, device and function,
// and compares the device with the pair currently selected.
// Assumes: iot_valid_i is a one-cycle strobe per instruction; the mode
// device codes are fixed and independent of the pair selected.
module iot_decode
    import console_iot_pkg::*;
#(
    parameter logic [DEV_W-1:0] CONS_RX = 6'o03,
    parameter logic [DEV_W-1:0] CONS_TX = 6'o04,
    parameter logic [DEV_W-1:0] SEC_RX  = 6'o36,
    parameter logic [DEV_W-1:0] SEC_TX  = 6'o37,
    parameter logic [DEV_W-1:0] MODE_DEV = 6'o41
) (
    input  logic              iot_valid_i,
    input  logic [WORD_W-1:0] iot_word_i,
    input  logic              secondary_i,
    output iot_cmd_t          cmd_o
);

    localparam int unsigned DEV_LSB = FN_W;
    localparam int unsigned OPC_LSB = FN_W + DEV_W;

    logic [OPC_W-1:0] opc;
    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  fn;
    logic [DEV_W-1:0] rx_code;
    logic [DEV_W-1:0] tx_code;
    logic             is_iot;

    // Field extraction
    always_comb begin
        opc = iot_word_i[WORD_W-1:OPC_LSB];
        dev = iot_word_i[OPC_LSB-1:DEV_LSB];
        fn  = iot_word_i[FN_W-1:0];
    end

    // Device code of the active pair
    always_comb begin
        rx_code = secondary_i ? SEC_RX : CONS_RX;
        tx_code = secondary_i ? SEC_TX : CONS_TX;
    end

    // Address match and command build
    always_comb begin
        is_iot          = iot_valid_i && (opc == IOT_OPCODE);
        cmd_o.fn        = fn;
        cmd_o.rx_hit    = is_iot && (dev == rx_code);
        cmd_o.tx_hit    = is_iot && (dev == tx_code);
        cmd_o.pick_cons = is_iot && (dev == MODE_DEV) && (fn == 3'd2);
        cmd_o.pick_sec  = is_iot && (dev == MODE_DEV) && (fn == 3'd3);
    end

endmodule

// File: rtl/rx_channel.sv
// Module: rx_channel
// Purpose: receive flag and character buffer; serves the skip, clear and
// read functions of the receiver device.
// Assumes: a new character (rx_ready_i) outranks a clear in the same cycle.
module rx_channel
    import console_iot_pkg::*;
#(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  iot_cmd_t          cmd_i,
    input  logic [CHAR_W-1:0] rx_byte_i,
    input  logic              rx_ready_i,
    output logic              flag_o,
    output logic              skip_o,
    output logic              clear_o,
    output logic              drive_o,
    output logic [WORD_W-1:0] data_o
);

    localparam int unsigned PAD_W = WORD_W - CHAR_W;

    logic              flag_q;
    logic [CHAR_W-1:0] buf_q;

    // Flag: set by a new character, cleared by function bit 1
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (rx_ready_i)
            flag_q <= 1'b1;
        else if (cmd_i.rx_hit && cmd_i.fn[FN_CLEAR])
            flag_q <= 1'b0;
    end

    // Buffer: capture each received character
    always_ff @(posedge clk) begin
        if (!rst_n)
            buf_q <= '0;
        else if (rx_ready_i)
            buf_q <= rx_byte_i;
    end

    // Bus response during the cycle
    always_comb begin
        skip_o  = cmd_i.rx_hit && cmd_i.fn[FN_SKIP] && flag_q;
        clear_o = cmd_i.rx_hit && cmd_i.fn[FN_CLEAR];
        drive_o = cmd_i.rx_hit && cmd_i.fn[FN_XFER];
        data_o  = drive_o ? {{PAD_W{1'b0}}, buf_q} : '0;
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/tx_channel.sv
// Module: tx_channel
// Purpose: transmit flag and load strobe for the transmitter device.
// Assumes: tx_empty_i outranks a clear in the same cycle; the flag comes
// out of reset set so that the first character can go at once.
module tx_channel
    import console_iot_pkg::*;
#(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  iot_cmd_t          cmd_i,
    input  logic [CHAR_W-1:0] ac_char_i,
    input  logic              tx_empty_i,
    output logic              flag_o,
    output logic              skip_o,
    output logic              load_o,
    output logic [CHAR_W-1:0] byte_o
);

    logic flag_q;

    // Flag: set when the transmitter empties, cleared by function bit 1
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b1;
        else if (tx_empty_i)
            flag_q <= 1'b1;
        else if (cmd_i.tx_hit && cmd_i.fn[FN_CLEAR])
            flag_q <= 1'b0;
    end

    // Bus response during the cycle
    always_comb begin
        skip_o = cmd_i.tx_hit && cmd_i.fn[FN_SKIP] && flag_q;
        load_o = cmd_i.tx_hit && cmd_i.fn[FN_XFER];
        byte_o = load_o ? ac_char_i : '0;
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/console_iot_ctrl.sv
// Module: console_iot_ctrl (top)
// Purpose: joins decode, the pair-select register, both channels, the
// interrupt request and the break-to-panel path.
// Assumes: one instruction per iot_valid_i strobe; strobes from the UART
// side are single-cycle and synchronous to clk.
module console_iot_ctrl
    import console_iot_pkg::*;
#(
    parameter int unsigned CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iot_valid_i,
    input  logic [11:0]       iot_word_i,
    input  logic [11:0]       ac_in_i,
    output logic              skip_o,
    output logic              ac_clear_o,
    output logic              ac_drive_o,
    output logic [11:0]       ac_data_o,
    output logic              irq_o,
    output logic              panel_req_o,
    input  logic              brk_en_i,
    input  logic [CHAR_W-1:0] rx_byte_i,
    input  logic              rx_ready_i,
    input  logic              rx_ferr_i,
    output logic [CHAR_W-1:0] tx_byte_o,
    output logic              tx_load_o,
    input  logic              tx_empty_i
);

    iot_cmd_t    cmd;
    logic        secondary_q;
    logic        rx_flag;
    logic        tx_flag;
    logic        rx_skip;
    logic        tx_skip;
    logic        rx_clear;
    logic        panel_q;
    logic [AC_HI_W-1:0] unused_ac_hi;

    localparam int unsigned AC_HI_W = WORD_W - CHAR_W;

    assign unused_ac_hi = ac_in_i[WORD_W-1:CHAR_W];

    iot_decode u_dec (
        .iot_valid_i (iot_valid_i),
        .iot_word_i  (iot_word_i),
        .secondary_i (secondary_q),
        .cmd_o       (cmd)
    );

    // Pair select: console after reset, changed by the mode instructions
    always_ff @(posedge clk) begin
        if (!rst_n)
            secondary_q <= 1'b0;
        else if (cmd.pick_sec)
            secondary_q <= 1'b1;
        else if (cmd.pick_cons)
            secondary_q <= 1'b0;
    end

    rx_channel #(.CHAR_W(CHAR_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd),
        .rx_byte_i  (rx_byte_i),
        .rx_ready_i (rx_ready_i),
        .flag_o     (rx_flag),
        .skip_o     (rx_skip),
        .clear_o    (rx_clear),
        .drive_o    (ac_drive_o),
        .data_o     (ac_data_o)
    );

    tx_channel #(.CHAR_W(CHAR_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd),
        .ac_char_i  (ac_in_i[CHAR_W-1:0]),
        .tx_empty_i (tx_empty_i),
        .flag_o     (tx_flag),
        .skip_o     (tx_skip),
        .load_o     (tx_load_o),
        .byte_o     (tx_byte_o)
    );

    // Break path: a framing error with break enabled requests the panel
    always_ff @(posedge clk) begin
        if (!rst_n)
            panel_q <= 1'b0;
        else
            panel_q <= rx_ferr_i && brk_en_i;
    end

    // Bus outputs and interrupt
    always_comb begin
        skip_o      = rx_skip || tx_skip;
        ac_clear_o  = rx_clear || cmd.pick_cons || cmd.pick_sec;
        irq_o       = rx_flag || tx_flag;
        panel_req_o = panel_q;
    end

endmodule

// File: rtl/console_iot_ctrl_chk.sv
// Module: console_iot_ctrl_chk
// Purpose: temporal checks on the controller, bound into the top module.
// Assumes: it sees the top's ports plus the two flags and the pair select.
module console_iot_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        iot_valid_i,
    input logic [11:0] iot_word_i,
    input logic [11:0] ac_in_i,
    input logic        skip_o,
    input logic        ac_clear_o,
    input logic        ac_drive_o,
    input logic [11:0] ac_data_o,
    input logic        irq_o,
    input logic        panel_req_o,
    input logic        brk_en_i,
    input logic        rx_ready_i,
    input logic        rx_ferr_i,
    input logic [7:0]  tx_byte_o,
    input logic        tx_load_o,
    input logic        tx_empty_i,
    input logic        rx_flag,
    input logic        tx_flag,
    input logic        secondary_q
);

    logic rx_clear_code;
    logic tx_clear_code;
    logic mode_code;

    assign rx_clear_code = iot_valid_i && (iot_word_i[11:9] == 3'o6) && iot_word_i[1]
                           && (iot_word_i[8:3] == (secondary_q ? 6'o36 : 6'o03));
    assign tx_clear_code = iot_valid_i && (iot_word_i[11:9] == 3'o6) && iot_word_i[1]
                           && (iot_word_i[8:3] == (secondary_q ? 6'o37 : 6'o04));
    assign mode_code     = iot_valid_i && ((iot_word_i == 12'o6412) || (iot_word_i == 12'o6413));

    AST_QUIET_OUTSIDE_IOT: assert property (@(posedge clk) disable iff (!rst_n)
        !iot_valid_i |-> !(skip_o || ac_clear_o || ac_drive_o || tx_load_o)); // R13

    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !ac_drive_o |-> (ac_data_o == 12'd0)); // R13

    AST_READ_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ac_drive_o |-> (ac_data_o[11:8] == 4'd0)); // R5

    AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_clear_code && !rx_ready_i) |=> !rx_flag); // R4

    AST_TX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_clear_code && !tx_empty_i) |=> !tx_flag); // R7

    AST_RX_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready_i |=> rx_flag); // R12

    AST_TX_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty_i |=> tx_flag); // R12

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (rx_flag || tx_flag)); // R10

    AST_MODE_CLEARS_AC: assert property (@(posedge clk) disable iff (!rst_n)
        mode_code |-> ac_clear_o); // R9

    AST_TX_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_o |-> (tx_byte_o == ac_in_i[7:0])); // R8

    AST_PANEL_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ferr_i && brk_en_i) |=> panel_req_o); // R11

    AST_PANEL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_ferr_i && brk_en_i) |=> !panel_req_o); // R11

endmodule

bind console_iot_ctrl console_iot_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .iot_valid_i (iot_valid_i),
    .iot_word_i  (iot_word_i),
    .ac_in_i     (ac_in_i),
    .skip_o      (skip_o),
    .ac_clear_o  (ac_clear_o),
    .ac_drive_o  (ac_drive_o),
    .ac_data_o   (ac_data_o),
    .irq_o       (irq_o),
    .panel_req_o (panel_req_o),
    .brk_en_i    (brk_en_i),
    .rx_ready_i  (rx_ready_i),
    .rx_ferr_i   (rx_ferr_i),
    .tx_byte_o   (tx_byte_o),
    .tx_load_o   (tx_load_o),
    .tx_empty_i  (tx_empty_i),
    .rx_flag     (rx_flag),
    .tx_flag     (tx_flag),
    .secondary_q (secondary_q)
);

// File: tb/console_iot_ctrl_test.sv
// Bench: behavioural reference model compared with every output each clock.
module console_iot_ctrl_test;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iot_valid_i = 1'b0;
    logic [11:0] iot_word_i = '0;
    logic [11:0] ac_in_i = '0;
    logic        skip_o, ac_clear_o, ac_drive_o, irq_o, panel_req_o, tx_load_o;
    logic [11:0] ac_data_o;
    logic [7:0]  tx_byte_o;
    logic        brk_en_i = 1'b0;
    logic [7:0]  rx_byte_i = '0;
    logic        rx_ready_i = 1'b0;
    logic        rx_ferr_i = 1'b0;
    logic        tx_empty_i = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state
    bit m_rxf, m_txf, m_sec, m_panel;
    int m_buf;

    always #(PERIOD/2) clk = ~clk;

    console_iot_ctrl uut (
        .clk(clk), .rst_n(rst_n), .iot_valid_i(iot_valid_i), .iot_word_i(iot_word_i),
        .ac_in_i(ac_in_i), .skip_o(skip_o), .ac_clear_o(ac_clear_o),
        .ac_drive_o(ac_drive_o), .ac_data_o(ac_data_o), .irq_o(irq_o),
        .panel_req_o(panel_req_o), .brk_en_i(brk_en_i), .rx_byte_i(rx_byte_i),
        .rx_ready_i(rx_ready_i), .rx_ferr_i(rx_ferr_i), .tx_byte_o(tx_byte_o),
        .tx_load_o(tx_load_o), .tx_empty_i(tx_empty_i)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One clock: drive inputs, compare outputs with the model, advance model.
    task automatic step(input string tag, input bit v, input int word, input int ac,
                        input bit rdy, input int rbyte, input bit ferr, input bit brk,
                        input bit emp);
        int opc, dev, fn, rxd, txd;
        bit is_iot, rxh, txh, msh, e_skip, e_clr, e_drv, e_load;
        @(negedge clk);
        iot_valid_i = v; iot_word_i = 12'(word); ac_in_i = 12'(ac);
        rx_ready_i = rdy; rx_byte_i = 8'(rbyte); rx_ferr_i = ferr; brk_en_i = brk;
        tx_empty_i = emp;
        #2;
        opc = (word >> 9) & 7; dev = (word >> 3) & 'o77; fn = word & 7;
        rxd = m_sec ? 'o36 : 'o03;
        txd = m_sec ? 'o37 : 'o04;
        is_iot = v && (opc == 6);
        rxh = is_iot && (dev == rxd);
        txh = is_iot && (dev == txd);
        msh = is_iot && (dev == 'o41) && (fn == 2 || fn == 3);
        e_skip = (rxh && fn[0] && m_rxf) || (txh && fn[0] && m_txf);
        e_clr  = (rxh && fn[1]) || msh;
        e_drv  = rxh && fn[2];
        e_load = txh && fn[2];
        check(tag, "skip", int'(skip_o), int'(e_skip));
        check(tag, "ac_clear", int'(ac_clear_o), int'(e_clr));
        check(tag, "ac_drive", int'(ac_drive_o), int'(e_drv));
        check(tag, "ac_data", int'(ac_data_o), e_drv ? m_buf : 0);
        check(tag, "tx_load", int'(tx_load_o), int'(e_load));
        check(tag, "tx_byte", int'(tx_byte_o), e_load ? (ac & 'hff) : 0);
        check(tag, "irq", int'(irq_o), int'(m_rxf || m_txf));
        check(tag, "panel", int'(panel_req_o), int'(m_panel));
        // Next state from the requirements
        if (rdy) begin m_rxf = 1; m_buf = rbyte & 'hff; end
        else if (rxh && fn[1]) m_rxf = 0;
        if (emp) m_txf = 1;
        else if (txh && fn[1]) m_txf = 0;
        if (msh) m_sec = (fn == 3);
        m_panel = ferr && brk;
    endtask

    task automatic iot(input string tag, input int word, input int ac);
        step(tag, 1, word, ac, 0, 0, 0, 0, 0);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        @(negedge clk); rst_n = 1'b1;
        m_rxf = 0; m_txf = 1; m_sec = 0; m_panel = 0; m_buf = 0;
        idle("R1");                       // reset state, irq from transmit flag
        iot("R1", 'o6041, 0);             // console transmitter answers, flag set
        iot("R3", 'o6031, 0);             // receive flag clear: no skip
        step("R12", 0, 0, 0, 1, 'hA5, 0, 0, 0);
        iot("R3", 'o6031, 0);             // now skips
        iot("R5", 'o6034, 'o7777);        // read without clear
        iot("R5", 'o6031, 0);             // flag kept
        iot("R4", 'o6032, 0);
        iot("R4", 'o6031, 0);
        iot("R2", 'o2031, 0);             // not an I/O opcode
        iot("R2", 'o6021, 0);             // other device
        step("R2", 0, 'o6036, 0, 0, 0, 0, 0, 0); // strobe low
        step("R12", 0, 0, 0, 1, 'h3C, 0, 0, 0);
        iot("R6", 'o6036, 0);
        iot("R6", 'o6031, 0);
        iot("R8", 'o6044, 'o1277);
        iot("R8", 'o6041, 0);
        iot("R7", 'o6042, 'o7777);
        iot("R10", 'o6041, 0);            // both flags clear: irq low
        step("R12", 0, 0, 0, 0, 0, 0, 0, 1);
        iot("R8", 'o6046, 'o0141);
        iot("R10", 'o6041, 0);
        step("R12", 0, 0, 0, 0, 0, 0, 0, 1);
        step("R12", 1, 'o6032, 0, 1, 'h5A, 0, 0, 0); // set beats clear
        iot("R12", 'o6034, 0);
        iot("R9", 'o6413, 'o7777);
        iot("R9", 'o6031, 0);             // console code now silent
        iot("R9", 'o6361, 0);             // secondary receiver skips
        iot("R9", 'o6376, 'o0042);        // secondary load and clear
        iot("R9", 'o6046, 'o0042);        // console transmitter silent
        iot("R9", 'o6412, 0);
        iot("R9", 'o6031, 0);
        step("R11", 0, 0, 0, 0, 0, 1, 0, 0); // break disabled
        idle("R11");
        step("R11", 0, 0, 0, 0, 0, 1, 1, 0);
        idle("R11");
        idle("R13");
        iot("R13", 'o6032, 0);
        idle("R13");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule